// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the column address for every data beat of one memory burst. A controller pulses a start input together with the column of the access, the burst length code and the ordering mode. From the next cycle the block presents one column per clock until the burst is complete. It drives a valid flag for the whole burst and a last flag on the final beat.

Only the low bits that fall inside the burst field change. The width of that field is log2 of the burst length. The column bits above the field stay fixed, so the sequence wraps inside its aligned block. Two orders are available. The wrapping order counts up from the start column modulo the burst length. The XOR order combines the start bits with the beat index. The burst ends early when a burst-stop pulse arrives. A fresh start pulse during a burst drops the old sequence and begins the new one at beat 0.

Top module: `col_burst_seq`

## Requirements
- R1: While reset is held and right after it is released, valid_o and last_o are 0.
- R2: A start_i sampled at a clock edge makes valid_o 1 in the following cycle, with col_o equal to start_col_i. The burst then lasts exactly BL valid cycles. len_i codes 0, 1, 2 and 3 select BL 2, 4, 8 and 16.
- R3: With xor_order_i = 0, the low log2(BL) bits of beat n are (start + n) mod BL. Example: start 2 with BL 4 gives 2, 3, 0, 1.
- R4: With xor_order_i = 1, the low log2(BL) bits of beat n are start XOR n. Example: start 5 with BL 8 gives 5, 4, 7, 6, 1, 0, 3, 2.
- R5: For every beat of a burst, all column bits above the low log2(BL) bits equal the start column.
- R6: last_o is 1 only on beat BL-1 of a burst, and only while valid_o is 1. In the cycle after the last beat, valid_o is 0 unless a new start was sampled.
- R7: len_i, xor_order_i and start_col_i are sampled only together with start_i. Changing them during a burst does not alter the sequence.
- R8: A stop_i sampled during a burst, at any burst length, makes valid_o and last_o 0 from the next cycle.
- R9: A start_i sampled during a burst restarts the sequence at beat 0 of the new column in the next cycle. When start_i and stop_i are sampled in the same cycle, start_i wins.
- R10: While idle, valid_o stays 0, and stop_i on its own has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins or restarts a burst |
| start_col_i | input | 9 | Start column of the burst |
| len_i | input | 2 | Burst length code: 0=2, 1=4, 2=8, 3=16 |
| xor_order_i | input | 1 | 0 selects the wrapping order, 1 selects the XOR order |
| stop_i | input | 1 | Ends the current burst |
| col_o | output | 9 | Column for the current beat; 0 when idle |
| valid_o | output | 1 | A beat is presented |
| last_o | output | 1 | Final beat of the burst |

## Verification
Directed bursts repeat the two worked examples. They also use a start column with the upper bits set, which separates the wrapping arithmetic from the preservation of the upper bits. Random bursts cover every length, both orders and random start columns. After each start the configuration inputs are scrambled, which shows that only the captured values steer the sequence. Separate cases stop a burst partway, restart a burst partway, assert start and stop together, and pulse stop while idle. These cases distinguish the priority between start, stop and the natural end of a burst.

// File: rtl/col_burst_pkg.sv
package col_burst_pkg;
  localparam int COL_W     = 9;
  localparam int LEN_CODES = 4;
  // code k selects BL = 2^(k+1), so the widest burst field is LEN_CODES bits
  localparam int BEAT_W    = LEN_CODES;
  localparam int CODE_W    = $clog2(LEN_CODES);

  typedef enum logic [CODE_W-1:0] {BLEN_2, BLEN_4, BLEN_8, BLEN_16} blen_e;
  typedef enum logic {ORD_WRAP = 1'b0, ORD_XOR = 1'b1} order_e;

  typedef struct packed {
    logic [COL_W-1:0] col;
    blen_e            len;
    order_e           ord;
  } burst_cfg_t;

  function automatic logic [BEAT_W-1:0] len_mask(blen_e l);
    logic [BEAT_W-1:0] m;
    for (int i = 0; i < BEAT_W; i++) m[i] = (i <= int'(l));
    return m;
  endfunction
endpackage

// File: rtl/cbs_cfg_hold.sv
module cbs_cfg_hold
  import col_burst_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  burst_cfg_t cfg_i,
  output burst_cfg_t cfg_o
);
  burst_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (load_i) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/cbs_beat_ctr.sv
module cbs_beat_ctr
  import col_burst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BEAT_W-1:0] mask_i,
  output logic              active_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              last_o
);
  logic              active_q;
  logic [BEAT_W-1:0] beat_q;
  logic              at_end;

  assign at_end = active_q && (beat_q == mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      beat_q   <= '0;
    end else if (stop_i || at_end) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else if (active_q) begin
      beat_q   <= beat_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;
  assign last_o   = at_end;
endmodule

// File: rtl/cbs_addr_map.sv
module cbs_addr_map
  import col_burst_pkg::*;
(
  input  burst_cfg_t        cfg_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [COL_W-1:0]  col_o
);
  logic [BEAT_W-1:0] mask;
  logic [BEAT_W-1:0] base_lo;
  logic [BEAT_W-1:0] wrap_lo;
  logic [BEAT_W-1:0] xor_lo;
  logic [BEAT_W-1:0] pick_lo;

  assign mask    = len_mask(cfg_i.len);
  assign base_lo = cfg_i.col[BEAT_W-1:0];
  assign wrap_lo = base_lo + beat_i;  // carries beyond the field are masked below
  assign xor_lo  = base_lo ^ beat_i;
  assign pick_lo = (cfg_i.ord == ORD_XOR) ? xor_lo : wrap_lo;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_field
    assign col_o[b] = mask[b] ? pick_lo[b] : base_lo[b];
  end

  assign col_o[COL_W-1:BEAT_W] = cfg_i.col[COL_W-1:BEAT_W];
endmodule

// File: rtl/col_burst_seq.sv
module col_burst_seq
  import col_burst_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [CODE_W-1:0] len_i,
  input  logic             xor_order_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  burst_cfg_t        cfg_in;
  burst_cfg_t        cfg_q;
  logic              active;
  logic [BEAT_W-1:0] beat;
  logic [COL_W-1:0]  col_map;

  assign cfg_in.col = start_col_i;
  assign cfg_in.len = blen_e'(len_i);
  assign cfg_in.ord = order_e'(xor_order_i);

  cbs_cfg_hold i_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i),
    .cfg_i  (cfg_in),
    .cfg_o  (cfg_q)
  );

  cbs_beat_ctr i_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .mask_i   (len_mask(cfg_q.len)),
    .active_o (active),
    .beat_o   (beat),
    .last_o   (last_o)
  );

  cbs_addr_map i_map (
    .cfg_i  (cfg_q),
    .beat_i (beat),
    .col_o  (col_map)
  );

  assign valid_o = active;
  assign col_o   = active ? col_map : '0;
endmodule

// File: rtl/cbs_checker.sv
module cbs_checker
  import col_burst_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             stop_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  AST_START_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o); // R2

  AST_START_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (col_o == $past(start_col_i))); // R9

  AST_STOP_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (!valid_o && !last_o)); // R8

  AST_LAST_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o); // R6

  AST_LAST_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !valid_o); // R6

  AST_UPPER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !start_i) |=> (!valid_o ||
      col_o[COL_W-1:BEAT_W] == $past(col_o[COL_W-1:BEAT_W]))); // R5
endmodule

bind col_burst_seq cbs_checker i_cbs_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .start_col_i (start_col_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o)
);

// File: tb/test_col_burst_seq.sv
module test_col_burst_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [1:0] len_i = '0;
  logic       xor_order_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [8:0] col_o;
  logic       valid_o;
  logic       last_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  col_burst_seq i_col_burst_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .len_i       (len_i),
    .xor_order_i (xor_order_i),
    .stop_i      (stop_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o)
  );

  function automatic int bl_of(int code);
    return 2 << code;
  endfunction

  function automatic logic [8:0] exp_col(logic [8:0] s, int code, bit ilv, int n);
    int bl = bl_of(code);
    int lo = int'(s) % bl;
    int v  = ilv ? (lo ^ n) : ((lo + n) % bl);
    return 9'(int'(s) - lo + v);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_idle(string tag);
    chk(valid_o == 1'b0, tag, "valid_o", int'(valid_o), 0);
    chk(last_o == 1'b0, tag, "last_o", int'(last_o), 0);
  endtask

  task automatic chk_beat(logic [8:0] s, int code, bit ilv, int n, string tag);
    logic [8:0] e = exp_col(s, code, ilv, n);
    bit el = (n == bl_of(code) - 1);
    chk(valid_o == 1'b1, "R2", "valid_o", int'(valid_o), 1);
    chk(col_o == e, tag, "col_o", int'(col_o), int'(e));
    chk(last_o == el, "R6", "last_o", int'(last_o), int'(el));
  endtask

  // drive a start, then scramble the config inputs (R7)
  task automatic launch(logic [8:0] s, int code, bit ilv);
    start_i = 1'b1;
    start_col_i = s;
    len_i = 2'(code);
    xor_order_i = ilv;
    @(negedge clk_i);
    start_i = 1'b0;
    start_col_i = 9'($urandom);
    len_i = 2'($urandom);
    xor_order_i = 1'($urandom);
  endtask

  task automatic full_burst(logic [8:0] s, int code, bit ilv, string tag);
    launch(s, code, ilv);
    for (int n = 0; n < bl_of(code); n++) begin
      chk_beat(s, code, ilv, n, tag);
      @(negedge clk_i);
    end
    chk_idle("R6");
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk_idle("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R1");

    // worked examples
    full_burst(9'd2, 1, 1'b0, "R3");
    full_burst(9'd5, 2, 1'b1, "R4");
    // upper bits preserved, wrap inside the field
    full_burst(9'h1F3, 3, 1'b0, "R5");
    full_burst(9'h1FD, 3, 1'b1, "R5");
    full_burst(9'h0AB, 0, 1'b0, "R5");

    // stop partway through a 16-beat burst
    launch(9'h155, 3, 1'b0);
    for (int n = 0; n < 4; n++) begin
      chk_beat(9'h155, 3, 1'b0, n, "R3");
      if (n < 3) @(negedge clk_i);
    end
    stop_i = 1'b1;
    @(negedge clk_i);
    stop_i = 1'b0;
    chk_idle("R8");

    // stop on the first beat of a 2-beat burst
    launch(9'h031, 0, 1'b1);
    chk_beat(9'h031, 0, 1'b1, 0, "R4");
    stop_i = 1'b1;
    @(negedge clk_i);
    stop_i = 1'b0;
    chk_idle("R8");

    // stop while idle has no effect
    stop_i = 1'b1;
    @(negedge clk_i);
    stop_i = 1'b0;
    chk_idle("R10");
    @(negedge clk_i);
    chk_idle("R10");

    // restart partway
    launch(9'h0A4, 2, 1'b0);
    for (int n = 0; n < 3; n++) begin
      chk_beat(9'h0A4, 2, 1'b0, n, "R3");
      if (n < 2) @(negedge clk_i);
    end
    start_i = 1'b1;
    start_col_i = 9'h013;
    len_i = 2'd1;
    xor_order_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int n = 0; n < 4; n++) begin
      chk_beat(9'h013, 1, 1'b1, n, "R9");
      @(negedge clk_i);
    end
    chk_idle("R9");

    // start and stop together: start wins
    launch(9'h100, 3, 1'b1);
    chk_beat(9'h100, 3, 1'b1, 0, "R4");
    start_i = 1'b1;
    stop_i = 1'b1;
    start_col_i = 9'h0C6;
    len_i = 2'd2;
    xor_order_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    stop_i = 1'b0;
    for (int n = 0; n < 8; n++) begin
      chk_beat(9'h0C6, 2, 1'b0, n, "R9");
      @(negedge clk_i);
    end
    chk_idle("R9");

    // random bursts, config scrambled after each start (R7)
    for (int k = 0; k < 60; k++) begin
      logic [8:0] s = 9'($urandom);
      int code = int'($urandom_range(3, 0));
      bit ilv = 1'($urandom);
      full_burst(s, code, ilv, ilv ? "R4" : "R3");
      if ($urandom_range(1, 0) == 1) @(negedge clk_i);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule